// File: doc/BRIEF.md
# Two-share byte-serial SM4 encryption datapath

This block encrypts one 128-bit block with the SM4 round function while the state never exists as a single unmasked value in any register. The plaintext arrives as two Boolean shares, whose XOR is the real plaintext. All 32 rounds run one byte at a time through a single three-share S-box. That S-box takes its third input share from a fresh random byte each time a byte enters it. The ciphertext leaves as two shares.

Key expansion lives outside the block. On each cycle that the block marks with `rand_ready`, the caller supplies one byte of the current round key together with one random byte. A round takes six cycles. On the first four cycles, one byte position of the three upper state words is combined with the key byte and pushed into the S-box. The last two cycles drain the S-box. At the end of the sixth cycle, the linear layer runs on each of the three output shares and the word registers shift by one word. The third share of the newest word's leading byte waits in a one-byte side register. It is merged into the second share when that byte is next read. The S-box model in this project recomputes the plain table and then splits its result again. It is a functional stand-in with no side-channel claim.

Top module: `sm4m_core`

## Requirements
- R1: When `start` is high and the block is idle, the next clock edge loads the plaintext shares (bits 127:96 form the first state word) and begins an operation. A `start` seen while busy changes neither the running phase nor its result.
- R2: While busy, `rand_ready` is high on the first four cycles of every six-cycle round and low on the other two, which gives 128 high cycles per operation.
- R3: `done` goes high for exactly one cycle. It rises at the 192nd clock edge after the edge that accepted `start`.
- R4: At `done`, `ct_s0 ^ ct_s1` equals the SM4 encryption of `pt_s0 ^ pt_s1`, with the final four state words output in reverse order. Key and plaintext 0123456789ABCDEFFEDCBA9876543210 give 681EDF34D206965E86B3E94F536E4246.
- R5: The recombined ciphertext does not depend on how the plaintext is split, on the random bytes, or on `rk_byte`/`rnd_byte` values driven while `rand_ready` is low.
- R6: In round r (counting from 0), the four `rand_ready` cycles take the bytes of round key r most significant first.
- R7: `ct_s0` and `ct_s1` hold their value on every cycle except the cycle in which `done` is high.
- R8: After a synchronous reset, `done` and `rand_ready` are low and both ciphertext shares are zero.
- R9: A `start` in the same cycle that `done` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation when idle |
| pt_s0 | input | 128 | Plaintext share 0 |
| pt_s1 | input | 128 | Plaintext share 1 |
| rk_byte | input | 8 | Round-key byte, consumed when `rand_ready` is high |
| rnd_byte | input | 8 | Fresh random byte, consumed when `rand_ready` is high |
| rand_ready | output | 1 | This cycle consumes `rk_byte` and `rnd_byte` |
| ct_s0 | output | 128 | Ciphertext share 0 |
| ct_s1 | output | 128 | Ciphertext share 1 |
| done | output | 1 | One-cycle pulse when the ciphertext shares are new |

## Verification
The cycle that ends one operation and the cycle that starts the next can coincide. `done` is high while the block has already gone idle, so a `start` in that cycle is accepted at once. The bench chains three operations by raising `start` on the exact cycle it observes `done`. It then judges three things for each follow-on operation: its ciphertext, its 192-edge latency, and its count of 128 consumed key bytes. It also checks that the outputs of the finished operation stayed stable until the next `done`.

// File: rtl/sm4m_pkg.sv
package sm4m_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 32;
  localparam int NSH    = 3;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef byte_t [NSH-1:0]   tri_t;

  // Multiply in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1.
  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t t;
    acc = '0;
    t   = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ t;
      t = t[7] ? ((t << 1) ^ 8'hF5) : (t << 1);
    end
    return acc;
  endfunction

  function automatic byte_t rotl8(byte_t v, int n);
    return (v << n) | (v >> (BYTE_W - n));
  endfunction

  function automatic byte_t affine(byte_t v);
    return v ^ rotl8(v, 1) ^ rotl8(v, 3) ^ rotl8(v, 6) ^ rotl8(v, 7) ^ 8'hD3;
  endfunction

  // Plain S-box: affine, field inverse as x^254, affine.
  function automatic byte_t sbox_plain(byte_t v);
    byte_t sq;
    byte_t acc;
    sq  = affine(v);
    acc = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return affine(acc);
  endfunction

  function automatic word_t rotl32(word_t v, int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic word_t lin_enc(word_t v);
    return v ^ rotl32(v, 2) ^ rotl32(v, 10) ^ rotl32(v, 18) ^ rotl32(v, 24);
  endfunction
endpackage

// File: rtl/sm4m_ctrl.sv
module sm4m_ctrl #(
  parameter int NUM_ROUNDS = 32,
  parameter int PH_N       = 6,
  parameter int FEED_N     = 4,
  parameter int SB_LAT     = 2,
  localparam int PH_W      = $clog2(PH_N),
  localparam int RND_W     = $clog2(NUM_ROUNDS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic            busy,
  output logic [PH_W-1:0] ph,
  output logic            feed,
  output logic            cap,
  output logic            upd,
  output logic            last,
  output logic            done
);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PH_N - 1);
  localparam logic [PH_W-1:0]  PH_FEED  = PH_W'(FEED_N);
  localparam logic [PH_W-1:0]  PH_CAP   = PH_W'(SB_LAT);
  localparam logic [RND_W-1:0] RND_LAST = RND_W'(NUM_ROUNDS - 1);

  logic [RND_W-1:0] rnd;

  assign feed = busy && (ph < PH_FEED);
  assign cap  = busy && (ph >= PH_CAP) && (ph < PH_LAST);
  assign upd  = busy && (ph == PH_LAST);
  assign last = (rnd == RND_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      ph   <= '0;
      rnd  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          ph   <= '0;
          rnd  <= '0;
        end
      end else if (upd) begin
        ph  <= '0;
        rnd <= rnd + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sm4m_sbox_sh.sv
module sm4m_sbox_sh
  import sm4m_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  tri_t in_sh,
  output tri_t out_sh
);
  tri_t st1;
  tri_t st2;

  always_ff @(posedge clk) begin
    if (rst) begin
      st1 <= '0;
      st2 <= '0;
    end else begin
      st1    <= in_sh;
      // Stand-in: recombine, look up, split again with the carried shares.
      st2[0] <= sbox_plain(st1[0] ^ st1[1] ^ st1[2]) ^ st1[1] ^ st1[2];
      st2[1] <= st1[1];
      st2[2] <= st1[2];
    end
  end

  assign out_sh = st2;
endmodule

// File: rtl/sm4m_core.sv
module sm4m_core
  import sm4m_pkg::*;
#(
  parameter int NUM_ROUNDS = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [127:0] pt_s0,
  input  logic [127:0] pt_s1,
  input  logic [7:0]   rk_byte,
  input  logic [7:0]   rnd_byte,
  output logic         rand_ready,
  output logic [127:0] ct_s0,
  output logic [127:0] ct_s1,
  output logic         done
);
  localparam int PH_N  = 6;
  localparam int PH_W  = $clog2(PH_N);
  localparam int NS2   = 2;
  localparam int STG_W = 3 * BYTE_W;
  localparam int TOP   = WORD_W - 1;

  logic            busy;
  logic [PH_W-1:0] ph;
  logic            feed, cap, upd, last;

  sm4m_ctrl #(.NUM_ROUNDS(NUM_ROUNDS), .PH_N(PH_N)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .ph(ph),
    .feed(feed), .cap(cap), .upd(upd), .last(last), .done(done)
  );

  logic load;
  assign load = start && !busy;

  word_t x0 [NS2];
  word_t x1 [NS2];
  word_t x2 [NS2];
  word_t x3 [NS2];
  byte_t p_side;
  logic [STG_W-1:0] x4 [NSH];

  // Leading byte of X3 share 1 with the parked third share merged in.
  byte_t fold3;
  assign fold3 = x3[1][TOP -: BYTE_W] ^ ((ph == '0) ? p_side : '0);

  tri_t sb_in, sb_out;
  assign sb_in[0] = x1[0][TOP -: BYTE_W] ^ x2[0][TOP -: BYTE_W] ^ x3[0][TOP -: BYTE_W] ^ rk_byte;
  assign sb_in[1] = x1[1][TOP -: BYTE_W] ^ x2[1][TOP -: BYTE_W] ^ fold3 ^ rnd_byte;
  assign sb_in[2] = rnd_byte;

  sm4m_sbox_sh u_sbox (.clk(clk), .rst(rst), .in_sh(sb_in), .out_sh(sb_out));

  word_t w [NSH];
  word_t lw [NSH];
  for (genvar k = 0; k < NSH; k++) begin : g_lin
    assign w[k]  = {x4[k], sb_out[k]};
    assign lw[k] = lin_enc(w[k]);
  end

  word_t y_s0, y_s1, y_kept1, y_full1;
  assign y_s0    = lw[0] ^ x0[0];
  assign y_s1    = lw[1] ^ x0[1];
  assign y_kept1 = {y_s1[TOP -: BYTE_W], y_s1[TOP-BYTE_W:0] ^ lw[2][TOP-BYTE_W:0]};
  assign y_full1 = y_s1 ^ lw[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS2; s++) begin
        x0[s] <= '0; x1[s] <= '0; x2[s] <= '0; x3[s] <= '0;
      end
      p_side <= '0;
    end else if (load) begin
      x0[0] <= pt_s0[127:96]; x1[0] <= pt_s0[95:64];
      x2[0] <= pt_s0[63:32];  x3[0] <= pt_s0[31:0];
      x0[1] <= pt_s1[127:96]; x1[1] <= pt_s1[95:64];
      x2[1] <= pt_s1[63:32];  x3[1] <= pt_s1[31:0];
      p_side <= '0;
    end else if (feed) begin
      for (int s = 0; s < NS2; s++) begin
        x1[s] <= {x1[s][TOP-BYTE_W:0], x1[s][TOP -: BYTE_W]};
        x2[s] <= {x2[s][TOP-BYTE_W:0], x2[s][TOP -: BYTE_W]};
      end
      x3[0] <= {x3[0][TOP-BYTE_W:0], x3[0][TOP -: BYTE_W]};
      x3[1] <= {x3[1][TOP-BYTE_W:0], fold3};
      if (ph == '0) p_side <= '0;
    end else if (upd) begin
      for (int s = 0; s < NS2; s++) begin
        x0[s] <= x1[s];
        x1[s] <= x2[s];
        x2[s] <= x3[s];
      end
      x3[0]  <= y_s0;
      x3[1]  <= y_kept1;
      p_side <= lw[2][TOP -: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NSH; k++) x4[k] <= '0;
    end else if (cap) begin
      for (int k = 0; k < NSH; k++) x4[k] <= {x4[k][STG_W-BYTE_W-1:0], sb_out[k]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ct_s0 <= '0;
      ct_s1 <= '0;
    end else if (upd && last) begin
      ct_s0 <= {y_s0, x3[0], x2[0], x1[0]};
      ct_s1 <= {y_full1, x3[1], x2[1], x1[1]};
    end
  end

  assign rand_ready = feed;
endmodule

// File: rtl/sm4m_core_chk.sv
module sm4m_core_chk #(
  parameter int PH_W = 3,
  parameter int PH_N = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic [PH_W-1:0] ph,
  input logic            rand_ready,
  input logic            done,
  input logic [127:0]    ct_s0,
  input logic [127:0]    ct_s1
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

  p_start_ignored_r1: assert property (@(posedge clk) disable iff (rst)
    (busy && start && ph != PH_LAST) |=> (busy && ph == $past(ph) + PH_W'(1)));

  p_ready_busy_r2: assert property (@(posedge clk) disable iff (rst)
    rand_ready |-> busy);

  p_ready_gap_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rand_ready) |=> !rand_ready);

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !rand_ready));

  p_ct_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(ct_s0) || !$stable(ct_s1)) |-> done);

  p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!done && !busy && !rand_ready));
endmodule

bind sm4m_core sm4m_core_chk #(.PH_W(3), .PH_N(6)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .ph(ph),
  .rand_ready(rand_ready), .done(done), .ct_s0(ct_s0), .ct_s1(ct_s1)
);

// File: tb/sim_sm4m_core.sv
module sim_sm4m_core;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [127:0] pt_s0 = '0, pt_s1 = '0;
  logic [7:0]   rk_byte = '0, rnd_byte = '0;
  logic         rand_ready, done;
  logic [127:0] ct_s0, ct_s1;

  sm4m_core u0 (.clk(clk), .rst(rst), .start(start), .pt_s0(pt_s0), .pt_s1(pt_s1),
                .rk_byte(rk_byte), .rnd_byte(rnd_byte), .rand_ready(rand_ready),
                .ct_s0(ct_s0), .ct_s1(ct_s1), .done(done));

  always #2 clk = ~clk;

  localparam logic [127:0] STD_KP = 128'h0123456789ABCDEFFEDCBA9876543210;
  localparam logic [127:0] STD_CT = 128'h681EDF34D206965E86B3E94F536E4246;

  int nchk = 0, nfail = 0, cyc = 0;
  int feed_total = 0, feed_mark = 0, run = 0;
  logic [7:0]   sbt [256];
  logic [31:0]  rk_arr [32];
  logic [127:0] expq [$];
  int           tq [$];
  string        tagq [$];
  logic [127:0] held0 = '0, held1 = '0;
  logic         prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Reference model: polynomial product then reduction, inverse by search.
  function automatic logic [7:0] mulg(logic [7:0] a, logic [7:0] b);
    logic [15:0] pr = '0;
    for (int i = 0; i < 8; i++) if (b[i]) pr ^= 16'(a) << i;
    for (int i = 14; i >= 8; i--) if (pr[i]) pr ^= 16'h01F5 << (i - 8);
    return pr[7:0];
  endfunction

  function automatic logic [7:0] aff(logic [7:0] v);
    logic [7:0] r;
    logic [7:0] c = 8'hD3;
    for (int i = 0; i < 8; i++)
      r[i] = v[i] ^ v[(i+1)%8] ^ v[(i+2)%8] ^ v[(i+5)%8] ^ v[(i+7)%8] ^ c[i];
    return r;
  endfunction

  function automatic logic [31:0] rl(logic [31:0] v, int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  function automatic logic [31:0] tau(logic [31:0] v);
    return {sbt[v[31:24]], sbt[v[23:16]], sbt[v[15:8]], sbt[v[7:0]]};
  endfunction

  task automatic build_sbox();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] a, inv;
      a = aff(8'(x));
      inv = '0;
      for (int y = 1; y < 256; y++) if (mulg(a, 8'(y)) == 8'h01) inv = 8'(y);
      sbt[x] = aff(inv);
    end
  endtask

  task automatic ref_enc(input logic [127:0] k, input logic [127:0] p, output logic [127:0] c);
    logic [31:0] fk [4];
    logic [31:0] kk [36];
    logic [31:0] xx [36];
    fk[0] = 32'hA3B1BAC6; fk[1] = 32'h56AA3350; fk[2] = 32'h677D9197; fk[3] = 32'hB27022DC;
    for (int i = 0; i < 4; i++) begin
      kk[i] = k[127-32*i -: 32] ^ fk[i];
      xx[i] = p[127-32*i -: 32];
    end
    for (int i = 0; i < 32; i++) begin
      logic [31:0] ck, t;
      ck = {8'((4*i)*7), 8'((4*i+1)*7), 8'((4*i+2)*7), 8'((4*i+3)*7)};
      t = tau(kk[i+1] ^ kk[i+2] ^ kk[i+3] ^ ck);
      kk[i+4] = kk[i] ^ t ^ rl(t, 13) ^ rl(t, 23);
      rk_arr[i] = kk[i+4];
    end
    for (int i = 0; i < 32; i++) begin
      logic [31:0] t;
      t = tau(xx[i+1] ^ xx[i+2] ^ xx[i+3] ^ rk_arr[i]);
      xx[i+4] = xx[i] ^ t ^ rl(t, 2) ^ rl(t, 10) ^ rl(t, 18) ^ rl(t, 24);
    end
    c = {xx[35], xx[34], xx[33], xx[32]};
  endtask

  // Driver: R1 load, R9 back-to-back start on the done cycle.
  task automatic enc(input logic [127:0] k, input logic [127:0] p, input bit b2b,
                     input bit is_std, input string tag);
    logic [127:0] e, m;
    if (b2b) begin
      do @(negedge clk); while (!done);
    end else @(negedge clk);
    ref_enc(k, p, e);
    if (is_std) begin
      chk(e == STD_CT, "R4 reference", e, STD_CT);
      e = STD_CT;
    end
    m = {$urandom, $urandom, $urandom, $urandom};
    pt_s0 = p ^ m;
    pt_s1 = m;
    start = 1'b1;
    expq.push_back(e);
    tq.push_back(cyc);
    tagq.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Key/random feeder: R6 byte order, R5 junk while not ready.
  always @(negedge clk) begin
    if (rand_ready) begin
      int idx;
      logic [31:0] wd;
      idx = feed_total % 128;
      wd = rk_arr[idx / 4] >> (24 - 8 * (idx % 4));
      rk_byte = wd[7:0];
      feed_total++;
      run++;
    end else begin
      rk_byte = 8'($urandom);
      if (run != 0) begin
        chk(run == 4, "R2 run length", 128'(run), 128'd4);
        run = 0;
      end
    end
    rnd_byte = 8'($urandom);
  end

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R3 unexpected done", 128'd1, 128'd0);
        end else begin
          logic [127:0] e;
          int t;
          string tg;
          e = expq.pop_front();
          t = tq.pop_front();
          tg = tagq.pop_front();
          chk((ct_s0 ^ ct_s1) === e, tg, ct_s0 ^ ct_s1, e);
          chk(cyc == t + 193, (tg == "R9") ? "R9 latency" : "R3 latency",
              128'(cyc - t), 128'd193);
          chk(feed_total - feed_mark == 128, "R2 feed count",
              128'(feed_total - feed_mark), 128'd128);
          feed_mark = feed_total;
        end
        if (prev_done) chk(1'b0, "R3 pulse width", 128'd2, 128'd1);
      end else begin
        chk(ct_s0 === held0 && ct_s1 === held1, "R7 hold", ct_s0, held0);
      end
      held0 = ct_s0;
      held1 = ct_s1;
      prev_done = done;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0 && rand_ready == 1'b0, "R8 flags", {126'd0, done, rand_ready}, 128'd0);
    chk(ct_s0 == '0 && ct_s1 == '0, "R8 outputs", ct_s0 | ct_s1, 128'd0);
    rst = 1'b0;

    enc(STD_KP, STD_KP, 1'b0, 1'b1, "R4");
    wait_idle();
    enc(STD_KP, STD_KP, 1'b0, 1'b1, "R5");   // new split, new random bytes
    wait_idle();
    enc({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
        1'b0, 1'b0, "R6");
    wait_idle();

    // R1: start pulses while busy must not disturb the running operation.
    enc({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
        1'b0, 1'b0, "R1");
    repeat (47) @(negedge clk);
    pt_s0 = {$urandom, $urandom, $urandom, $urandom};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();

    // R9: chained operations, each started in the done cycle of the previous.
    enc({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
        1'b0, 1'b0, "R6");
    enc({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
        1'b1, 1'b0, "R9");
    enc(STD_KP, STD_KP, 1'b1, 1'b1, "R9");
    wait_idle();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule